// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Protocol Monitor

This block watches the control pins of one DDR SDRAM rank on every rising clock edge and names the command that the memory sees. It keeps the clock-enable value of the previous edge in a register of its own. Decoding uses both that value and the current one, so that power-down entry, self-refresh entry and wake-up are told apart from ordinary commands. The block also tracks each of the four banks as idle or open.

It counts down the windows in which a bank must not be touched: after a read or a write that carries auto-precharge, and after a precharge when a mode-register write follows. It reports each decoded command with its bank, a violation pulse and a code that says what rule was broken. Burst length, precharge time and write-recovery time come in as static configuration. The block is passive: it drives nothing towards the memory and is meant to sit beside a controller, in a bench or in silicon, as a protocol monitor.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While reset is asserted and after release, until the first decoded edge, the outputs read `cmd_o`=0 (NOP), `bank_o`=0, `viol_o`=0 and `viol_code_o`=0. Reset closes all banks, clears every lockout, and the precharge time counts as already elapsed, so a mode-register write on the first edge is legal.
- R2: The result of the edge at which the pins are sampled appears on the outputs after that same edge, one cycle of latency. With the previous clock enable high and the current one high, chip select high gives DESEL=1. With chip select low, {ras_ni,cas_ni,we_ni} decodes as follows: 111 gives NOP=0, 011 gives ACT=2, 101 gives RD=3 or RDA=4, 100 gives WR=5 or WRA=6, 010 gives PRE=7 or PREA=8, 110 gives BST=9, 001 gives REF=10 and 000 gives MRS=14.
- R3: Clock-enable transitions are decoded as follows. Previous high and current low, with chip select high or the 111 encoding, gives power-down entry: 12 when all banks are idle and 13 when any bank is open. Previous high and current low with the 001 encoding gives self-refresh entry, 11. Previous low and current high gives WAKE=15. Previous low and current low gives NOP=0. None of these is checked.
- R4: The `ap_i` pin selects auto-precharge for reads and writes, and all banks for a precharge. For PREA, REF and self-refresh entry, `bank_o` reads 0 whatever `ba_i` holds. For MRS, `bank_o` carries `ba_i`, which tells the normal and extended mode registers apart.
- R5: ACT opens the addressed bank. An ACT to a bank that is already open is flagged with code 1.
- R6: RD, RDA, WR, WRA or BST to an idle bank is flagged with code 1.
- R7: PRE closes the addressed bank and PREA closes all banks. A PRE to an idle bank is legal.
- R8: After a legal RDA at edge n, a command at edge n+k, with 1 <= k < `cfg_bl_half_i`+`cfg_trp_i`, is flagged with code 2 if it addresses that bank. The commands that count are ACT, RD, RDA, WR, WRA, PRE and BST naming the bank, and PREA, REF, self-refresh entry and MRS, which address every bank. The bank is idle from edge n+1.
- R9: After a legal WRA at edge n, the same lockout applies for 1 <= k < `cfg_bl_half_i`+1+`cfg_twr_i`+`cfg_trp_i`.
- R10: MRS is flagged with code 3 when any bank is open, or when fewer than `cfg_trp_i` edges have passed since the last legal PRE or PREA.
- R11: REF or self-refresh entry while any bank is open is flagged with code 4.
- R12: A lockout (code 2) takes precedence over every other code. A flagged command changes no bank state and starts no timer. `viol_o` is high exactly when `viol_code_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory clock, rising edge samples pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ap_i | input | 1 | Auto-precharge / all-banks address pin |
| ba_i | input | 2 | Bank address |
| cfg_bl_half_i | input | 4 | Burst length divided by two, in cycles (static) |
| cfg_trp_i | input | 4 | Precharge time in cycles (static) |
| cfg_twr_i | input | 4 | Write-recovery time in cycles (static) |
| cmd_o | output | 4 | Decoded command code (R2, R3) |
| bank_o | output | 2 | Bank of the decoded command |
| viol_o | output | 1 | Violation pulse for the decoded command |
| viol_code_o | output | 3 | 0 none, 1 bank state, 2 lockout, 3 mode timing, 4 refresh while open |

## Verification
Every result is registered once, so the command, bank and violation for pins driven before edge n are due just after edge n. The bench drives on the falling edge and compares one time unit after the following rising edge. Lockout and precharge windows are expressed in the reference model as absolute edge numbers at which a bank or the mode register becomes free again. A command at edge n+k is compared against that edge count, which checks both the last flagged edge and the first legal one of every window.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_ACT      = 4'd2,
    CMD_RD       = 4'd3,
    CMD_RDA      = 4'd4,
    CMD_WR       = 4'd5,
    CMD_WRA      = 4'd6,
    CMD_PRE      = 4'd7,
    CMD_PREA     = 4'd8,
    CMD_BST      = 4'd9,
    CMD_REF      = 4'd10,
    CMD_SRE      = 4'd11,
    CMD_PDN_IDLE = 4'd12,
    CMD_PDN_OPEN = 4'd13,
    CMD_MRS      = 4'd14,
    CMD_WAKE     = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    VIO_NONE    = 3'd0,
    VIO_BANK    = 3'd1,
    VIO_LOCK    = 3'd2,
    VIO_MODE    = 3'd3,
    VIO_REFOPEN = 3'd4
  } vio_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_prev_i,
  input  logic            cke_cur_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic            ap_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            open_any_i,
  output cmd_e            cmd_o,
  output logic [BA_W-1:0] bank_o,
  output logic            tgt_one_o,
  output logic            tgt_all_o
);
  cmd_e pdn_cmd;
  assign pdn_cmd = open_any_i ? CMD_PDN_OPEN : CMD_PDN_IDLE;

  always_comb begin
    cmd_o     = CMD_NOP;
    bank_o    = '0;
    tgt_one_o = 1'b0;
    tgt_all_o = 1'b0;
    if (!cke_prev_i) begin
      cmd_o = cke_cur_i ? CMD_WAKE : CMD_NOP;
    end else if (cs_ni) begin
      cmd_o = cke_cur_i ? CMD_DESEL : pdn_cmd;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000: begin
          cmd_o = CMD_MRS; bank_o = ba_i; tgt_all_o = 1'b1;
        end
        3'b001: begin
          cmd_o = cke_cur_i ? CMD_REF : CMD_SRE; tgt_all_o = 1'b1;
        end
        3'b010: begin
          if (ap_i) begin
            cmd_o = CMD_PREA; tgt_all_o = 1'b1;
          end else begin
            cmd_o = CMD_PRE; bank_o = ba_i; tgt_one_o = 1'b1;
          end
        end
        3'b011: begin
          cmd_o = CMD_ACT; bank_o = ba_i; tgt_one_o = 1'b1;
        end
        3'b100: begin
          cmd_o = ap_i ? CMD_WRA : CMD_WR; bank_o = ba_i; tgt_one_o = 1'b1;
        end
        3'b101: begin
          cmd_o = ap_i ? CMD_RDA : CMD_RD; bank_o = ba_i; tgt_one_o = 1'b1;
        end
        3'b110: begin
          cmd_o = CMD_BST; bank_o = ba_i; tgt_one_o = 1'b1;
        end
        default: cmd_o = cke_cur_i ? CMD_NOP : pdn_cmd;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_mon_pkg::*;
#(
  parameter  int BA_W   = 2,
  parameter  int CFG_W  = 4,
  localparam int NB     = 1 << BA_W,
  localparam int LOCK_W = CFG_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             legal_i,
  input  logic [CFG_W-1:0] cfg_bl_half_i,
  input  logic [CFG_W-1:0] cfg_trp_i,
  input  logic [CFG_W-1:0] cfg_twr_i,
  output logic [NB-1:0]    open_o,
  output logic [NB-1:0]    lock_o
);
  logic [LOCK_W-1:0] rd_win, wr_win;

  // counters hold "edges still forbidden", loaded one below the window length
  assign rd_win = LOCK_W'(cfg_bl_half_i) + LOCK_W'(cfg_trp_i) - LOCK_W'(1);
  assign wr_win = LOCK_W'(cfg_bl_half_i) + LOCK_W'(cfg_twr_i) + LOCK_W'(cfg_trp_i);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [LOCK_W-1:0] cnt_q;
    logic              open_q;
    logic              hit;

    assign hit = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - LOCK_W'(1);
        if (legal_i) begin
          if (cmd_i == CMD_PREA) begin
            open_q <= 1'b0;
          end else if (hit) begin
            case (cmd_i)
              CMD_ACT: open_q <= 1'b1;
              CMD_PRE: open_q <= 1'b0;
              CMD_RDA: begin open_q <= 1'b0; cnt_q <= rd_win; end
              CMD_WRA: begin open_q <= 1'b0; cnt_q <= wr_win; end
              default: ;
            endcase
          end
        end
      end
    end

    assign open_o[b] = open_q;
    assign lock_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/ddr_pre_timer.sv
module ddr_pre_timer #(
  parameter int CFG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic [CFG_W-1:0] cfg_trp_i,
  output logic             busy_o
);
  logic [CFG_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (pre_i) begin
      rem_q <= (cfg_trp_i == '0) ? '0 : cfg_trp_i - CFG_W'(1);
    end else if (rem_q != '0) begin
      rem_q <= rem_q - CFG_W'(1);
    end
  end

  assign busy_o = (rem_q != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int CFG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic             ap_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [CFG_W-1:0] cfg_bl_half_i,
  input  logic [CFG_W-1:0] cfg_trp_i,
  input  logic [CFG_W-1:0] cfg_twr_i,
  output logic [3:0]       cmd_o,
  output logic [BA_W-1:0]  bank_o,
  output logic             viol_o,
  output logic [2:0]       viol_code_o
);
  localparam int NB = 1 << BA_W;

  logic            cke_q;
  cmd_e            dec_cmd;
  logic [BA_W-1:0] dec_bank;
  logic            tgt_one, tgt_all;
  logic [NB-1:0]   open_v, lock_v;
  logic            open_any, pre_busy, legal, pre_evt;
  vio_e            code;

  cmd_e            cmd_q;
  logic [BA_W-1:0] bank_q;
  vio_e            code_q;
  logic            viol_q;

  assign open_any = |open_v;

  ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cke_prev_i (cke_q),
    .cke_cur_i  (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .ap_i       (ap_i),
    .ba_i       (ba_i),
    .open_any_i (open_any),
    .cmd_o      (dec_cmd),
    .bank_o     (dec_bank),
    .tgt_one_o  (tgt_one),
    .tgt_all_o  (tgt_all)
  );

  always_comb begin
    code = VIO_NONE;
    if ((tgt_one && lock_v[dec_bank]) || (tgt_all && |lock_v)) begin
      code = VIO_LOCK;
    end else begin
      case (dec_cmd)
        CMD_ACT: if (open_v[dec_bank]) code = VIO_BANK;
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_BST:
          if (!open_v[dec_bank]) code = VIO_BANK;
        CMD_MRS: if (open_any || pre_busy) code = VIO_MODE;
        CMD_REF, CMD_SRE: if (open_any) code = VIO_REFOPEN;
        default: ;
      endcase
    end
  end

  assign legal   = (code == VIO_NONE);
  assign pre_evt = legal && (dec_cmd == CMD_PRE || dec_cmd == CMD_PREA);

  ddr_bank_tracker #(.BA_W(BA_W), .CFG_W(CFG_W)) u_banks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (dec_cmd),
    .bank_i        (dec_bank),
    .legal_i       (legal),
    .cfg_bl_half_i (cfg_bl_half_i),
    .cfg_trp_i     (cfg_trp_i),
    .cfg_twr_i     (cfg_twr_i),
    .open_o        (open_v),
    .lock_o        (lock_v)
  );

  ddr_pre_timer #(.CFG_W(CFG_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_i     (pre_evt),
    .cfg_trp_i (cfg_trp_i),
    .busy_o    (pre_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      code_q <= VIO_NONE;
      viol_q <= 1'b0;
    end else begin
      cke_q  <= cke_i;
      cmd_q  <= dec_cmd;
      bank_q <= dec_bank;
      code_q <= code;
      viol_q <= !legal;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_o      = bank_q;
  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_i,
  input logic [3:0]      cmd_o,
  input logic [BA_W-1:0] bank_o,
  input logic            viol_o,
  input logic [2:0]      viol_code_o
);
  // R3: a wake-up is only reported after clock enable went low then high
  a_r3_wake_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WAKE) |-> ($past(cke_i) && !$past(cke_i, 2)));

  // R11: refresh-while-open code belongs to refresh commands only
  a_r11_refopen_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == VIO_REFOPEN) |-> (cmd_o == CMD_REF || cmd_o == CMD_SRE));

  // R10: mode timing code belongs to mode register writes only
  a_r10_mode_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == VIO_MODE) |-> (cmd_o == CMD_MRS));

  // R6: bank-state code only on bank-addressed data or activate commands
  a_r6_bank_code_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == VIO_BANK) |-> (cmd_o inside {CMD_ACT, CMD_RD, CMD_RDA,
                                                 CMD_WR, CMD_WRA, CMD_BST}));

  // R5: two back-to-back activates of one bank cannot both be legal
  a_r5_no_double_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT && !viol_o) |=>
      (!(cmd_o == CMD_ACT && bank_o == $past(bank_o)) || viol_o));

  // R7: right after a legal precharge-all no read or write can be legal
  a_r7_prea_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PREA && !viol_o) |=>
      !((cmd_o inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA}) && !viol_o));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.BA_W(BA_W)) u_chk (.*);

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic       ap_i = 1'b0;
  logic [1:0] ba_i = '0;
  logic [3:0] cfg_bl_half_i = 4'd2, cfg_trp_i = 4'd3, cfg_twr_i = 4'd2;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic       viol_o;
  logic [2:0] viol_code_o;

  int n_chk = 0, n_err = 0;

  // reference model state: absolute edge numbers
  int  cyc = 0;
  int  free_at [4];
  bit  open_m [4];
  int  mrs_ok = 0;
  bit  cke_prev = 1'b1;

  always #5 clk_i = ~clk_i;

  ddr_cmd_monitor dut (.*);

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic compare(input int ec, input int eb, input int ecode, input string tag);
    n_chk++;
    if (cmd_o !== 4'(ec) || bank_o !== 2'(eb) || viol_code_o !== 3'(ecode) ||
        viol_o !== (ecode != 0)) begin
      n_err++;
      $display("FAIL %s: cmd=%0d bank=%0d viol=%0b code=%0d expected cmd=%0d bank=%0d viol=%0b code=%0d",
               tag, cmd_o, bank_o, viol_o, viol_code_o, ec, eb, ecode != 0, ecode);
    end
  endtask

  task automatic step(input bit cke, cs, ras, cas, we, ap, input int ba, input string tag);
    int ec, eb, ecode;
    bit one, all, any_open, any_lock, lk;
    @(negedge clk_i);
    cke_i = cke; cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we; ap_i = ap;
    ba_i = 2'(ba);
    ec = 0; eb = 0; ecode = 0; one = 0; all = 0;
    any_open = 0; any_lock = 0;
    for (int i = 0; i < 4; i++) begin
      if (open_m[i]) any_open = 1;
      if (cyc < free_at[i]) any_lock = 1;
    end
    if (!cke_prev) ec = cke ? 15 : 0;
    else if (cs) ec = cke ? 1 : (any_open ? 13 : 12);
    else begin
      case ({ras, cas, we})
        3'b000: begin ec = 14; eb = ba; all = 1; end
        3'b001: begin ec = cke ? 10 : 11; all = 1; end
        3'b010: if (ap) begin ec = 8; all = 1; end else begin ec = 7; eb = ba; one = 1; end
        3'b011: begin ec = 2; eb = ba; one = 1; end
        3'b100: begin ec = ap ? 6 : 5; eb = ba; one = 1; end
        3'b101: begin ec = ap ? 4 : 3; eb = ba; one = 1; end
        3'b110: begin ec = 9; eb = ba; one = 1; end
        default: ec = cke ? 0 : (any_open ? 13 : 12);
      endcase
    end
    lk = (one && cyc < free_at[ba]) || (all && any_lock);
    if (lk) ecode = 2;
    else if (ec == 2 && open_m[ba]) ecode = 1;
    else if ((ec inside {3, 4, 5, 6, 9}) && !open_m[ba]) ecode = 1;
    else if (ec == 14 && (any_open || cyc < mrs_ok)) ecode = 3;
    else if ((ec == 10 || ec == 11) && any_open) ecode = 4;
    if (ecode == 0) begin
      case (ec)
        2: open_m[ba] = 1;
        4: begin open_m[ba] = 0; free_at[ba] = cyc + int'(cfg_bl_half_i) + int'(cfg_trp_i); end
        6: begin open_m[ba] = 0;
             free_at[ba] = cyc + int'(cfg_bl_half_i) + 1 + int'(cfg_twr_i) + int'(cfg_trp_i); end
        7: begin open_m[ba] = 0; mrs_ok = cyc + int'(cfg_trp_i); end
        8: begin for (int i = 0; i < 4; i++) open_m[i] = 0; mrs_ok = cyc + int'(cfg_trp_i); end
        default: ;
      endcase
    end
    cke_prev = cke;
    cyc++;
    @(posedge clk_i);
    #1;
    compare(ec, eb, ecode, tag);
  endtask

  task automatic nop(input string tag);  step(1, 0, 1, 1, 1, 0, 0, tag); endtask
  task automatic act(input int b, input string tag); step(1, 0, 0, 1, 1, 0, b, tag); endtask
  task automatic rd(input int b, input bit ap, input string tag); step(1, 0, 1, 0, 1, ap, b, tag); endtask
  task automatic wr(input int b, input bit ap, input string tag); step(1, 0, 1, 0, 0, ap, b, tag); endtask
  task automatic pre(input int b, input bit ap, input string tag); step(1, 0, 0, 1, 0, ap, b, tag); endtask
  task automatic mrs(input int b, input string tag); step(1, 0, 0, 0, 0, 0, b, tag); endtask
  task automatic refr(input string tag); step(1, 0, 0, 0, 1, 0, 0, tag); endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin free_at[i] = 0; open_m[i] = 0; end
    #12;
    compare(0, 0, 0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare(0, 0, 0, "R1 after release");
    mrs(0, "R1 mode write right after reset");
    mrs(1, "R10 extended mode write");
    act(0, "R5 activate");
    act(0, "R5 reactivate open bank");
    rd(0, 0, "R12 flagged activate kept bank open");
    wr(0, 0, "R2 write");
    wr(1, 0, "R6 write idle bank");
    step(1, 0, 1, 1, 0, 0, 2, "R6 burst stop idle bank");
    act(1, "R5 activate bank1");
    step(0, 0, 1, 1, 1, 0, 0, "R3 power-down with bank open");
    step(0, 1, 1, 1, 1, 0, 0, "R3 clock enable held low");
    step(1, 1, 1, 1, 1, 0, 0, "R3 wake");
    refr("R11 refresh with banks open");
    mrs(0, "R10 mode write with banks open");
    pre(0, 0, "R7 precharge bank0");
    rd(0, 0, "R7 read after precharge");
    pre(3, 1, "R4 precharge all ignores bank pins");
    mrs(0, "R10 mode write one edge after precharge");
    mrs(0, "R10 mode write two edges after precharge");
    mrs(0, "R10 mode write at precharge time");
    refr("R11 refresh all idle");
    step(0, 0, 0, 0, 1, 0, 0, "R3 self-refresh entry");
    step(0, 0, 0, 0, 1, 0, 0, "R3 self-refresh hold");
    step(1, 1, 1, 1, 1, 0, 0, "R3 self-refresh exit");
    step(1, 1, 1, 1, 1, 0, 3, "R2 deselect");
    step(0, 1, 1, 1, 1, 0, 0, "R3 precharge power-down");
    step(1, 1, 1, 1, 1, 0, 0, "R3 wake idle");
    act(2, "R8 open bank2");
    rd(2, 1, "R8 read with auto-precharge");
    act(2, "R8 activate inside read lockout");
    rd(2, 0, "R12 lockout outranks idle bank");
    act(3, "R8 other bank unaffected");
    act(2, "R8 last locked edge");
    act(2, "R8 first free edge");
    act(1, "R9 open bank1");
    wr(1, 1, "R9 write with auto-precharge");
    nop("R9 wait");
    nop("R9 wait");
    pre(0, 1, "R9 precharge all inside write lockout");
    nop("R9 wait"); nop("R9 wait"); nop("R9 wait");
    act(1, "R9 last locked edge");
    act(1, "R9 first free edge");
    pre(3, 0, "R7 precharge open bank3");
    pre(3, 0, "R7 precharge idle bank3");
    cfg_bl_half_i = 4'd4;
    act(0, "R8 open bank0 longer burst");
    rd(0, 1, "R8 auto-precharge read longer burst");
    for (int k = 0; k < 5; k++) nop("R8 wait");
    act(0, "R8 last locked edge longer burst");
    act(0, "R8 first free edge longer burst");
    wr(0, 0, "R2 write after reopen");
    report();
  end
endmodule